// File: doc/BRIEF.md
# Reset Source Arbitration Controller

This block merges three reset sources into one reset-type indication for the rest of the chip. The sources are an asynchronous external reset pin (active low), a reset request from the debug interface, and an overflow pulse from the watchdog counter. Pin and debug requests always produce a power-on reset that reinitializes every register. A watchdog overflow is honoured only while the watchdog runs in reset-generating mode. A select bit then makes it raise either a power-on reset or a manual reset. In either case the block raises a qualifier that tells downstream logic to preserve the watchdog control register and the clock frequency register.

When a pin or debug request lands in the same cycle as a watchdog overflow, the pin or debug request wins and the watchdog overflow flag is cleared. An accepted overflow sets the flag, and software clears it later. After the last request cycle the chosen reset type and the qualifier are held for a fixed number of cycles, so that slow consumers see a clean window.

Top module: `reset_source_arbiter`

## Requirements
- R1: While `sys_rst` is high at a clock edge, after that edge `rst_kind` is 3'b001 (none), `keep_regs` is 0 and `wdt_flag` is 0.
- R2: A low level on `pin_rst_n` produces `rst_kind` = 3'b010 (power-on) with `keep_regs` = 0. Assertion takes effect asynchronously in the synchronizer. The request is released only after the pin has been seen high at two consecutive clock edges.
- R3: `dbg_rst_req` high at a clock edge produces `rst_kind` = 3'b010 with `keep_regs` = 0 after that edge.
- R4: `wdt_ovf` with `wdt_en` = 1 and `wdt_manual` = 0, with no pin or debug request, produces `rst_kind` = 3'b010 with `keep_regs` = 1 after that edge.
- R5: `wdt_ovf` with `wdt_en` = 1 and `wdt_manual` = 1, with no pin or debug request, produces `rst_kind` = 3'b100 (manual) with `keep_regs` = 1 after that edge.
- R6: `wdt_ovf` while `wdt_en` = 0 has no effect on `rst_kind`, `keep_regs` or `wdt_flag`.
- R7: A pin or debug request in the same cycle as an accepted overflow gives `rst_kind` = 3'b010, `keep_regs` = 0 and `wdt_flag` = 0. Any pin or debug request clears the flag.
- R8: An accepted overflow without a pin or debug request sets `wdt_flag` to 1. The flag stays set until `flag_clr` is high at an edge that carries no accepted overflow and no pin or debug request. An accepted overflow takes precedence over `flag_clr` in the same cycle.
- R9: Any request cycle reloads a hold counter with HOLD_CYCLES and replaces the held type and qualifier. With no further requests, the output returns to none with `keep_regs` = 0 exactly HOLD_CYCLES edges after the last request edge.
- R10: `rst_kind` has exactly one bit set in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Synchronous active-high initialization of the block itself |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous |
| dbg_rst_req | input | 1 | Reset request from the debug interface |
| wdt_ovf | input | 1 | Watchdog counter overflow pulse |
| wdt_en | input | 1 | Watchdog is in reset-generating mode |
| wdt_manual | input | 1 | 1: overflow raises a manual reset, 0: power-on reset |
| flag_clr | input | 1 | Software write of 0 to the overflow flag |
| rst_kind | output | 3 | One-hot reset type: bit0 none, bit1 power-on, bit2 manual |
| keep_regs | output | 1 | Preserve watchdog control and clock frequency registers |
| wdt_flag | output | 1 | Watchdog overflow flag |

## Verification
The assertions assume that all inputs except `pin_rst_n` are synchronous to `clk`, and that any low pulse on `pin_rst_n` covers at least one rising edge. The stimulus therefore changes every input one time unit after a rising edge and holds it for whole cycles, the pin included. The bench reference model treats the pin as sampled at edges: the request is active unless the pin was high at the current edge and at the two edges before it. This matches the synchronizer only under the whole-cycle assumption that the stimulus keeps.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  typedef logic [2:0] rst_kind_t;
  localparam rst_kind_t RK_NONE = 3'b001;
  localparam rst_kind_t RK_POR  = 3'b010;
  localparam rst_kind_t RK_MAN  = 3'b100;
endpackage

// File: rtl/rsa_pin_sync.sv
module rsa_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic sys_rst,
  input  logic pin_n,
  output logic pin_req
);
  logic [STAGES-1:0] sh_q;

  // Asynchronous assertion through the pin, synchronous release.
  always_ff @(posedge clk or negedge pin_n) begin
    if (!pin_n)       sh_q <= '0;
    else if (sys_rst) sh_q <= '0;
    else              sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign pin_req = !sh_q[STAGES-1];
endmodule

// File: rtl/rsa_resolve.sv
module rsa_resolve
  import rsa_pkg::*;
(
  input  logic      pin_req,
  input  logic      dbg_req,
  input  logic      wdt_ovf,
  input  logic      wdt_en,
  input  logic      wdt_manual,
  output logic      any_req,
  output logic      hw_req,
  output logic      wdt_fire,
  output rst_kind_t kind,
  output logic      keep
);
  always_comb begin
    hw_req   = pin_req | dbg_req;
    wdt_fire = wdt_ovf & wdt_en & !hw_req;
    any_req  = hw_req | wdt_fire;
    kind     = RK_NONE;
    keep     = 1'b0;
    if (hw_req) begin
      kind = RK_POR;
    end else if (wdt_fire) begin
      kind = wdt_manual ? RK_MAN : RK_POR;
      keep = 1'b1;
    end
  end
endmodule

// File: rtl/rsa_stretch.sv
module rsa_stretch
  import rsa_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic      clk,
  input  logic      sys_rst,
  input  logic      load,
  input  rst_kind_t load_kind,
  input  logic      load_keep,
  output rst_kind_t kind_q,
  output logic      keep_q
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      cnt_q  <= '0;
      kind_q <= RK_NONE;
      keep_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= HOLD_V;
      kind_q <= load_kind;
      keep_q <= load_keep;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        kind_q <= RK_NONE;
        keep_q <= 1'b0;
      end
    end
  end

  // R9
  hold_end_chk: assert property (@(posedge clk) disable iff (sys_rst)
    (!load && cnt_q == CW'(1)) |=> (kind_q == RK_NONE && !keep_q));

  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (sys_rst)
    (!load && cnt_q > CW'(1)) |=> $stable(kind_q) && $stable(keep_q));

  // R10
  kind_onehot_chk: assert property (@(posedge clk) disable iff (sys_rst)
    $countones(kind_q) == 1);
endmodule

// File: rtl/reset_source_arbiter.sv
module reset_source_arbiter
  import rsa_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       sys_rst,
  input  logic       pin_rst_n,
  input  logic       dbg_rst_req,
  input  logic       wdt_ovf,
  input  logic       wdt_en,
  input  logic       wdt_manual,
  input  logic       flag_clr,
  output logic [2:0] rst_kind,
  output logic       keep_regs,
  output logic       wdt_flag
);
  logic      pin_req, any_req, hw_req, wdt_fire, nxt_keep;
  rst_kind_t nxt_kind, kind_q;

  rsa_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .sys_rst(sys_rst), .pin_n(pin_rst_n), .pin_req(pin_req)
  );

  rsa_resolve u_res (
    .pin_req(pin_req), .dbg_req(dbg_rst_req), .wdt_ovf(wdt_ovf),
    .wdt_en(wdt_en), .wdt_manual(wdt_manual), .any_req(any_req),
    .hw_req(hw_req), .wdt_fire(wdt_fire), .kind(nxt_kind), .keep(nxt_keep)
  );

  rsa_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .sys_rst(sys_rst), .load(any_req), .load_kind(nxt_kind),
    .load_keep(nxt_keep), .kind_q(kind_q), .keep_q(keep_regs)
  );

  assign rst_kind = kind_q;

  // Overflow flag: pin/debug clear it, accepted overflow sets it, software clears.
  always_ff @(posedge clk) begin
    if (sys_rst)       wdt_flag <= 1'b0;
    else if (hw_req)   wdt_flag <= 1'b0;
    else if (wdt_fire) wdt_flag <= 1'b1;
    else if (flag_clr) wdt_flag <= 1'b0;
  end

  // R3
  dbg_por_chk: assert property (@(posedge clk) disable iff (sys_rst)
    dbg_rst_req |=> (rst_kind == RK_POR && !keep_regs));

  // R2
  pin_por_chk: assert property (@(posedge clk) disable iff (sys_rst)
    pin_req |=> (rst_kind == RK_POR && !keep_regs));

  // R4
  wdt_por_chk: assert property (@(posedge clk) disable iff (sys_rst)
    (wdt_ovf && wdt_en && !wdt_manual && !dbg_rst_req && !pin_req)
      |=> (rst_kind == RK_POR && keep_regs && wdt_flag));

  // R5
  wdt_man_chk: assert property (@(posedge clk) disable iff (sys_rst)
    (wdt_ovf && wdt_en && wdt_manual && !dbg_rst_req && !pin_req)
      |=> (rst_kind == RK_MAN && keep_regs && wdt_flag));

  // R7
  hw_clears_flag_chk: assert property (@(posedge clk) disable iff (sys_rst)
    (dbg_rst_req || pin_req) |=> !wdt_flag);

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (sys_rst)
    (wdt_flag && !flag_clr && !dbg_rst_req && !pin_req) |=> wdt_flag);
endmodule

// File: tb/reset_source_arbiter_tb_top.sv
`timescale 1ns/1ps
module reset_source_arbiter_tb_top;
  localparam int HOLD = 16;
  localparam int MAX_CYC = 20000;

  logic clk = 1'b0;
  logic sys_rst = 1'b1;
  logic pin_rst_n = 1'b1;
  logic dbg_rst_req = 1'b0, wdt_ovf = 1'b0, wdt_en = 1'b0;
  logic wdt_manual = 1'b0, flag_clr = 1'b0;
  logic [2:0] rst_kind;
  logic keep_regs, wdt_flag;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";
  bit done = 1'b0;

  // reference model state
  int pin_hist[$];
  int m_kind = 1, m_keep = 0, m_flag = 0, m_cnt = 0;

  always #2 clk = ~clk;

  reset_source_arbiter #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .sys_rst(sys_rst), .pin_rst_n(pin_rst_n),
    .dbg_rst_req(dbg_rst_req), .wdt_ovf(wdt_ovf), .wdt_en(wdt_en),
    .wdt_manual(wdt_manual), .flag_clr(flag_clr), .rst_kind(rst_kind),
    .keep_regs(keep_regs), .wdt_flag(wdt_flag)
  );

  always @(posedge clk) begin
    bit preq, hw, fire;
    cyc++;
    if (sys_rst) begin
      pin_hist = {0, 0};
      m_kind = 1; m_keep = 0; m_flag = 0; m_cnt = 0;
    end else begin
      preq = !(pin_rst_n && pin_hist[0] != 0 && pin_hist[1] != 0);
      pin_hist.push_front(int'(pin_rst_n));
      void'(pin_hist.pop_back());
      hw = preq || dbg_rst_req;
      fire = wdt_ovf && wdt_en && !hw;
      if (hw) begin
        m_kind = 2; m_keep = 0; m_cnt = HOLD;
      end else if (fire) begin
        m_kind = wdt_manual ? 4 : 2; m_keep = 1; m_cnt = HOLD;
      end else if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin m_kind = 1; m_keep = 0; end
      end
      if (hw) m_flag = 0;
      else if (fire) m_flag = 1;
      else if (flag_clr) m_flag = 0;
    end
  end

  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      n_cmp += 4;
      if (int'(rst_kind) != m_kind) begin
        n_bad++;
        $display("FAIL %s rst_kind actual=%b expected=%0d @%0d", tag, rst_kind, m_kind, cyc);
      end
      if (int'(keep_regs) != m_keep) begin
        n_bad++;
        $display("FAIL %s keep_regs actual=%0d expected=%0d @%0d", tag, keep_regs, m_keep, cyc);
      end
      if (int'(wdt_flag) != m_flag) begin
        n_bad++;
        $display("FAIL %s wdt_flag actual=%0d expected=%0d @%0d", tag, wdt_flag, m_flag, cyc);
      end
      if ($countones(rst_kind) != 1) begin
        n_bad++;
        $display("FAIL R10 rst_kind actual=%b expected one-hot @%0d", rst_kind, cyc);
      end
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic pulses_off();
    dbg_rst_req = 0; wdt_ovf = 0; flag_clr = 0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    finish_run();
  end

  initial begin
    tag = "R1"; step(3); sys_rst = 0; #0;
    tag = "R2"; step(HOLD + 6);              // post-init pin sync release
    tag = "R3"; dbg_rst_req = 1; step(1); pulses_off(); step(HOLD + 2);
    tag = "R4"; wdt_en = 1; wdt_manual = 0; wdt_ovf = 1; step(1); pulses_off(); step(HOLD + 2);
    tag = "R8"; step(3); flag_clr = 1; step(1); pulses_off(); step(2);
    tag = "R5"; wdt_manual = 1; wdt_ovf = 1; step(1); pulses_off(); step(HOLD + 2);
    tag = "R8"; wdt_ovf = 1; flag_clr = 1; step(1); pulses_off(); step(2);
    flag_clr = 1; step(1); pulses_off(); step(HOLD);
    tag = "R6"; wdt_en = 0; wdt_ovf = 1; step(1); pulses_off(); step(4);
    tag = "R7"; wdt_en = 1; wdt_ovf = 1; step(1); pulses_off(); step(2);
    wdt_ovf = 1; dbg_rst_req = 1; step(1); pulses_off(); step(HOLD + 2);
    wdt_ovf = 1; step(1); pulses_off(); step(HOLD + 2);
    pin_rst_n = 0; wdt_ovf = 1; step(1); pulses_off(); step(3);
    tag = "R2"; pin_rst_n = 1; step(HOLD + 5);
    tag = "R9"; wdt_manual = 1; wdt_ovf = 1; step(1); pulses_off(); step(HOLD - 3);
    dbg_rst_req = 1; step(1); pulses_off(); step(5);
    wdt_ovf = 1; step(1); pulses_off(); step(HOLD + 3);
    tag = "R10";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      dbg_rst_req = (r < 2);
      wdt_ovf = (r >= 10 && r < 14);
      flag_clr = (r >= 20 && r < 25);
      wdt_en = ($urandom_range(0, 3) != 0);
      wdt_manual = $urandom_range(0, 1) != 0;
      if (r == 50) pin_rst_n = 0;
      else if (r > 60) pin_rst_n = 1;
      step(1);
    end
    pulses_off(); pin_rst_n = 1; step(HOLD + 5);
    tag = "R1"; sys_rst = 1; step(2); sys_rst = 0; step(HOLD + 4);
    finish_run();
  end
endmodule